// File: doc/BRIEF.md
# Matrix Element Index Remapper

This block turns the step number of an ordinary linear vector loop into an element index that treats the vector as a 2D or 3D array. Four shapes are held side by side. Each shape has its own x, y and z sizes and its own loop-nesting order. All four step together, so up to four operands of one loop can each follow a different walk. Typical walks are row order, transposed order, or the three nested loops of a matrix multiply.

A configuration write stores one shape. Each size field is 5 bits wide and holds the size minus one. A start pulse rewinds every walk to element 0 and latches the vector length. Each later advance strobe moves every walk forward by one step. The block raises a done flag on the last step of the loop. Every index is registered: it shows the new value in the cycle after the pulse or strobe that caused it.

Top module: `mir_remapper`

## Requirements
- R1: A cycle with `cfg_we` high stores the three size codes and the order code into shape `cfg_sel`. A size code c means a size of c+1, so sizes run from 1 to 32. The four shapes are independent, and writing one leaves the others unchanged. After reset every code is 0.
- R2: A start pulse latches `vl_i` and rewinds every walk to step 0. In the next cycle all four indices read 0. A start pulse also restarts a walk that is in progress or already done.
- R3: Let the counters of a shape be x, y and z, and its sizes X, Y and Z. The index of that shape is x + X*y + X*Y*z.
- R4: The order code names the counters from innermost to outermost. The codes are: 0 = x,y,z; 1 = y,x,z; 2 = x,z,y; 3 = z,x,y; 4 = y,z,x; 5 = z,y,x. Codes 6 and 7 act as 0. With X=Y=3 and order 1, the walk begins 0, 3, 6, 1, 4, 7.
- R5: Sizes need not be powers of two. Each step increments the innermost counter. A counter at its size minus one returns to 0 and carries into the next one out. When all three counters wrap, the shape starts again at index 0.
- R6: `done_o` is high exactly when the step number equals L-1. Here L is the smaller of the latched `vl_i` and the element count X*Y*Z of shape 0. If L is 0 or 1, `done_o` is high in the cycle right after start.
- R7: An advance strobe has no effect while `done_o` is high, and none before the first start after reset. Start takes priority over a simultaneous advance. After reset, `done_o` is low and all indices are 0.
- R8: The indices and `done_o` change only in the cycle after a start or an accepted advance. In any other cycle they hold their values.
- R9: A 5x4x3 shape 0 with a vector length of 127 gives exactly 60 steps: `done_o` rises after the 59th advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for a shape configuration |
| cfg_sel | input | 2 | Shape number written |
| cfg_xcode | input | 5 | x size minus one |
| cfg_ycode | input | 5 | y size minus one |
| cfg_zcode | input | 5 | z size minus one |
| cfg_order | input | 3 | Loop-nesting order code |
| start | input | 1 | Rewind all walks and latch the vector length |
| advance | input | 1 | Step all walks forward by one |
| vl_i | input | 7 | Vector length, 0 to 127 |
| idx_o | output | 60 | Four 15-bit indices; shape s in bits [15s+14:15s] |
| done_o | output | 1 | Last step of the loop reached |

## Verification
Directed walks cover these cases:
- A transposed 3x3 walk, compared against the literal sequence. This separates the inner counter from the outer one.
- A 3x4 and a 5x3 shape. These expose any carry logic that assumes power-of-two wrap points.
- A 5x4x3 run, which pins the end of the loop to the element count of shape 0.
- A short vector length, which pins the end of the loop to the vector length instead.

Random walks then give all four shapes different sizes and orders. Idle gaps are mixed in, and extra advances are sent after done. A model that splits the step number into digits, by division rather than by carry, predicts every index. A mismatch therefore points to the nesting order, the wrap rule, or the hold and ignore behaviour.

// File: rtl/mir_pkg.sv
`timescale 1ns/1ps
package mir_pkg;
  localparam int DIM_W  = 5;
  localparam int ORD_W  = 3;
  localparam int IDX_W  = 3 * DIM_W;
  localparam int PROD_W = 3 * DIM_W + 1;

  typedef struct packed {
    logic [DIM_W-1:0] xc;
    logic [DIM_W-1:0] yc;
    logic [DIM_W-1:0] zc;
    logic [ORD_W-1:0] ord;
  } shape_cfg_t;

  // axis numbers: 0 = x, 1 = y, 2 = z
  typedef struct packed {
    logic [1:0] inner;
    logic [1:0] mid;
    logic [1:0] outer;
  } nest_t;

  function automatic nest_t decode_order(input logic [ORD_W-1:0] ord);
    nest_t n;
    case (ord)
      3'd1:    n = '{inner: 2'd1, mid: 2'd0, outer: 2'd2};
      3'd2:    n = '{inner: 2'd0, mid: 2'd2, outer: 2'd1};
      3'd3:    n = '{inner: 2'd2, mid: 2'd0, outer: 2'd1};
      3'd4:    n = '{inner: 2'd1, mid: 2'd2, outer: 2'd0};
      3'd5:    n = '{inner: 2'd2, mid: 2'd1, outer: 2'd0};
      default: n = '{inner: 2'd0, mid: 2'd1, outer: 2'd2};
    endcase
    return n;
  endfunction
endpackage

// File: rtl/mir_cfg_bank.sv
`timescale 1ns/1ps
module mir_cfg_bank
  import mir_pkg::*;
#(
  parameter int NSHAPE = 4,
  localparam int SEL_W = $clog2(NSHAPE)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [SEL_W-1:0] sel,
  input  shape_cfg_t       wdata,
  output shape_cfg_t       cfg_o [NSHAPE]
);
  shape_cfg_t cfg_q [NSHAPE];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NSHAPE; i++) cfg_q[i] <= '0;
    end else if (we) begin
      cfg_q[sel] <= wdata;
    end
  end

  always_comb begin
    for (int i = 0; i < NSHAPE; i++) cfg_o[i] = cfg_q[i];
  end
endmodule

// File: rtl/mir_step_ctrl.sv
`timescale 1ns/1ps
module mir_step_ctrl
  import mir_pkg::*;
#(
  parameter int VL_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              advance,
  input  logic [VL_W-1:0]   vl_i,
  input  logic [PROD_W-1:0] prod0_i,
  output logic              step_o,
  output logic              done_o
);
  logic              active_q;
  logic              done_q;
  logic [VL_W-1:0]   cnt_q;
  logic [VL_W-1:0]   last_q;
  logic [PROD_W-1:0] vl_ext;
  logic [PROD_W-1:0] lim;
  logic [VL_W-1:0]   last_c;
  logic [VL_W-1:0]   cnt_inc;

  assign vl_ext  = PROD_W'(vl_i);
  assign lim     = (prod0_i < vl_ext) ? prod0_i : vl_ext;
  assign last_c  = (lim == '0) ? '0 : VL_W'(lim - 1'b1);
  assign cnt_inc = cnt_q + 1'b1;
  assign step_o  = advance && active_q && !done_q && !start;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      cnt_q    <= '0;
      last_q   <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
      last_q   <= last_c;
      done_q   <= (last_c == '0);
    end else if (step_o) begin
      cnt_q    <= cnt_inc;
      done_q   <= (cnt_inc == last_q);
    end
  end

  assign done_o = done_q;
endmodule

// File: rtl/mir_walker.sv
`timescale 1ns/1ps
module mir_walker
  import mir_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  shape_cfg_t       cfg,
  input  logic             start,
  input  logic             step,
  output logic [IDX_W-1:0] idx_o
);
  logic [DIM_W-1:0] cnt_q [3];
  logic [DIM_W-1:0] cnt_n [3];
  logic [DIM_W-1:0] top_v [3];
  logic [DIM_W:0]   xsz, ysz;
  logic [IDX_W-1:0] idx_n;
  nest_t            nest;

  assign top_v[0] = cfg.xc;
  assign top_v[1] = cfg.yc;
  assign top_v[2] = cfg.zc;
  assign nest     = decode_order(cfg.ord);
  assign xsz      = {1'b0, cfg.xc} + 1'b1;
  assign ysz      = {1'b0, cfg.yc} + 1'b1;

  always_comb begin
    for (int i = 0; i < 3; i++) cnt_n[i] = cnt_q[i];
    if (cnt_q[nest.inner] != top_v[nest.inner]) begin
      cnt_n[nest.inner] = cnt_q[nest.inner] + 1'b1;
    end else begin
      cnt_n[nest.inner] = '0;
      if (cnt_q[nest.mid] != top_v[nest.mid]) begin
        cnt_n[nest.mid] = cnt_q[nest.mid] + 1'b1;
      end else begin
        cnt_n[nest.mid] = '0;
        if (cnt_q[nest.outer] != top_v[nest.outer])
          cnt_n[nest.outer] = cnt_q[nest.outer] + 1'b1;
        else
          cnt_n[nest.outer] = '0;
      end
    end
  end

  assign idx_n = IDX_W'(cnt_n[0])
               + IDX_W'(xsz) * (IDX_W'(cnt_n[1]) + IDX_W'(ysz) * IDX_W'(cnt_n[2]));

  always_ff @(posedge clk) begin
    if (rst || start) begin
      for (int i = 0; i < 3; i++) cnt_q[i] <= '0;
      idx_o <= '0;
    end else if (step) begin
      for (int i = 0; i < 3; i++) cnt_q[i] <= cnt_n[i];
      idx_o <= idx_n;
    end
  end
endmodule

// File: rtl/mir_remapper.sv
`timescale 1ns/1ps
module mir_remapper
  import mir_pkg::*;
#(
  parameter int NSHAPE = 4,
  parameter int VL_W   = 7,
  localparam int SEL_W = $clog2(NSHAPE)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_we,
  input  logic [SEL_W-1:0]        cfg_sel,
  input  logic [DIM_W-1:0]        cfg_xcode,
  input  logic [DIM_W-1:0]        cfg_ycode,
  input  logic [DIM_W-1:0]        cfg_zcode,
  input  logic [ORD_W-1:0]        cfg_order,
  input  logic                    start,
  input  logic                    advance,
  input  logic [VL_W-1:0]         vl_i,
  output logic [NSHAPE*IDX_W-1:0] idx_o,
  output logic                    done_o
);
  shape_cfg_t        wdata;
  shape_cfg_t        cfg [NSHAPE];
  logic              step;
  logic [PROD_W-1:0] prod0;

  assign wdata = '{xc: cfg_xcode, yc: cfg_ycode, zc: cfg_zcode, ord: cfg_order};

  mir_cfg_bank #(.NSHAPE(NSHAPE)) u_bank (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(wdata), .cfg_o(cfg)
  );

  assign prod0 = (PROD_W'(cfg[0].xc) + 1'b1)
               * (PROD_W'(cfg[0].yc) + 1'b1)
               * (PROD_W'(cfg[0].zc) + 1'b1);

  mir_step_ctrl #(.VL_W(VL_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .advance(advance), .vl_i(vl_i),
    .prod0_i(prod0), .step_o(step), .done_o(done_o)
  );

  for (genvar s = 0; s < NSHAPE; s++) begin : g_walk
    mir_walker u_walk (
      .clk(clk), .rst(rst), .cfg(cfg[s]), .start(start), .step(step),
      .idx_o(idx_o[s*IDX_W +: IDX_W])
    );
  end
endmodule

// File: rtl/mir_remapper_chk.sv
`timescale 1ns/1ps
module mir_remapper_chk #(
  parameter int NW = 60
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          advance,
  input logic [NW-1:0] idx_o,
  input logic          done_o
);
  // R2: a start pulse rewinds every index to zero
  a_r2_start_rewinds: assert property (@(posedge clk) disable iff (rst)
    start |=> (idx_o == '0));

  // R8: with neither start nor advance, outputs hold
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!start && !advance) |=> ($stable(idx_o) && $stable(done_o)));

  // R7: once done, only a start can move the outputs
  a_r7_done_freezes: assert property (@(posedge clk) disable iff (rst)
    (done_o && !start) |=> (done_o && $stable(idx_o)));

  // R6: done rises only as a result of a start or an advance
  a_r6_done_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> ($past(start) || $past(advance)));
endmodule

bind mir_remapper mir_remapper_chk #(.NW(NSHAPE * mir_pkg::IDX_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .advance(advance),
  .idx_o(idx_o), .done_o(done_o)
);

// File: tb/sim_mir_remapper.sv
`timescale 1ns/1ps
module sim_mir_remapper;
  localparam int NS = 4;
  localparam int IW = 15;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [4:0] cfg_xcode = '0, cfg_ycode = '0, cfg_zcode = '0;
  logic [2:0] cfg_order = '0;
  logic start = 1'b0, advance = 1'b0;
  logic [6:0] vl_i = '0;
  logic [NS*IW-1:0] idx_o;
  logic done_o;

  int n_chk = 0, n_fail = 0;
  int bx[NS], by[NS], bz[NS], bo[NS];
  bit finished = 0;

  always #2.5 clk = ~clk;

  mir_remapper u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_xcode(cfg_xcode), .cfg_ycode(cfg_ycode), .cfg_zcode(cfg_zcode),
    .cfg_order(cfg_order), .start(start), .advance(advance), .vl_i(vl_i),
    .idx_o(idx_o), .done_o(done_o)
  );

  function automatic int exp_idx(int s, int k);
    int d[3]; int c[3]; int ri, rm, ro; int kk;
    d[0] = bx[s] + 1; d[1] = by[s] + 1; d[2] = bz[s] + 1;
    case (bo[s])
      1: begin ri = 1; rm = 0; ro = 2; end
      2: begin ri = 0; rm = 2; ro = 1; end
      3: begin ri = 2; rm = 0; ro = 1; end
      4: begin ri = 1; rm = 2; ro = 0; end
      5: begin ri = 2; rm = 1; ro = 0; end
      default: begin ri = 0; rm = 1; ro = 2; end
    endcase
    kk = k % (d[0] * d[1] * d[2]);
    c[ri] = kk % d[ri];
    c[rm] = (kk / d[ri]) % d[rm];
    c[ro] = kk / (d[ri] * d[rm]);
    return c[0] + d[0] * c[1] + d[0] * d[1] * c[2];
  endfunction

  function automatic int last_step(int vl);
    int p, l;
    p = (bx[0] + 1) * (by[0] + 1) * (bz[0] + 1);
    l = (vl < p) ? vl : p;
    return (l <= 1) ? 0 : l - 1;
  endfunction

  task automatic chk(string tag, int k, bit exp_done);
    bit bad = 0;
    n_chk++;
    for (int s = 0; s < NS; s++) begin
      if (int'(idx_o[s*IW +: IW]) != exp_idx(s, k)) begin
        bad = 1;
        $display("FAIL %s step %0d shape %0d idx actual %0d expected %0d",
                 tag, k, s, idx_o[s*IW +: IW], exp_idx(s, k));
      end
    end
    if (done_o !== exp_done) begin
      bad = 1;
      $display("FAIL %s step %0d done actual %0b expected %0b", tag, k, done_o, exp_done);
    end
    if (bad) n_fail++;
  endtask

  task automatic set_shape(int s, int x, int y, int z, int o);
    cfg_we = 1; cfg_sel = 2'(s); cfg_xcode = 5'(x); cfg_ycode = 5'(y);
    cfg_zcode = 5'(z); cfg_order = 3'(o);
    @(negedge clk);
    cfg_we = 0;
    bx[s] = x; by[s] = y; bz[s] = z; bo[s] = o;
  endtask

  task automatic pulse_start(int vl);
    start = 1; vl_i = 7'(vl);
    @(negedge clk);
    start = 0;
  endtask

  task automatic pulse_adv();
    advance = 1;
    @(negedge clk);
    advance = 0;
  endtask

  // full walk with optional idle gaps and post-done advances
  task automatic walk(string tag, int vl, bit gaps);
    int last; int k;
    last = last_step(vl);
    k = 0;
    pulse_start(vl);
    chk({tag, " R2 start"}, 0, last == 0);
    while (k < last) begin
      if (gaps && ($urandom % 3 == 0)) begin
        repeat (1 + $urandom % 2) @(negedge clk);
        chk("R8 idle hold", k, 0);
      end
      pulse_adv();
      k++;
      chk({tag, " R3 R5 R6 step"}, k, k == last);
    end
    pulse_adv();
    pulse_adv();
    chk("R7 advance after done", k, 1);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int k; int seq[6];
    void'($urandom(32'd20240611));
    for (int s = 0; s < NS; s++) begin bx[s] = 0; by[s] = 0; bz[s] = 0; bo[s] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R7 reset state", 0, 0);

    // R7: advance before any start is ignored
    pulse_adv();
    pulse_adv();
    chk("R7 advance before start", 0, 0);

    // R4: transposed 3x3 walk on shape 0, literal sequence
    set_shape(0, 2, 2, 0, 1);
    set_shape(1, 2, 2, 0, 0);
    set_shape(2, 2, 3, 0, 1);
    set_shape(3, 4, 2, 0, 0);
    seq = '{0, 3, 6, 1, 4, 7};
    pulse_start(127);
    for (int i = 0; i < 6; i++) begin
      n_chk++;
      if (int'(idx_o[IW-1:0]) != seq[i]) begin
        n_fail++;
        $display("FAIL R4 transposed step %0d actual %0d expected %0d", i, idx_o[IW-1:0], seq[i]);
      end
      if (i < 5) pulse_adv();
    end

    // R5: 3x4 and 5x3 shapes, plus R1 independence of the four shapes
    walk("R1 R5 non-pow2", 127, 0);

    // R2: restart in the middle of a walk, and start wins over advance
    pulse_start(127);
    pulse_adv(); pulse_adv(); pulse_adv();
    chk("R2 mid-walk", 3, 0);
    start = 1; advance = 1; vl_i = 7'd127;
    @(negedge clk);
    start = 0; advance = 0;
    chk("R2 R7 start priority", 0, 0);

    // R9: 5x4x3 gives exactly 60 steps
    set_shape(0, 4, 3, 2, 0);
    set_shape(1, 2, 4, 3, 5);
    set_shape(2, 3, 2, 4, 3);
    set_shape(3, 4, 3, 2, 0);
    pulse_start(127);
    k = 0;
    while (!done_o && k < 200) begin pulse_adv(); k++; end
    n_chk++;
    if (k != 59) begin
      n_fail++;
      $display("FAIL R9 advances to done actual %0d expected %0d", k, 59);
    end
    walk("R9 matmul", 127, 1);

    // R6: vector length shorter than shape; length 0 and 1
    walk("R6 short vl", 5, 0);
    walk("R6 vl one", 1, 0);
    walk("R6 vl zero", 0, 0);

    // R1: rewrite one shape, others keep their configuration
    set_shape(2, 6, 0, 1, 4);
    walk("R1 single rewrite", 20, 0);

    // random shapes, orders and lengths
    for (int r = 0; r < 25; r++) begin
      for (int s = 0; s < NS; s++)
        set_shape(s, $urandom % 8, $urandom % 8, $urandom % 4, $urandom % 8);
      walk("R4 R5 random", $urandom % 128, 1);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule